// File: doc/BRIEF.md
# Segmented Coarse Cell Code Generator

This block is the digital back end of a two-step coarse quantizer. It takes the decisions of 28 threshold comparators and reduces them to a 5-bit code that names which of 32 equal input cells holds the held sample. The comparators arrive in three groups:
- a 7-line coarse thermometer that fixes the upper three bits;
- a 7-line mid group that supplies the fourth bit;
- a 14-line fine group that supplies the last bit.

No 31-input encoder is built. The bits already resolved steer small 8:1 multiplexers, and each multiplexer picks the one comparator that matters for the cell group that has been found.

A strobe on `sample_i` latches all 28 comparator lines. The block then resolves the code in three clocked steps: first the upper group, then bit 1, then bit 0. One cycle after the last step it raises `valid_o` with the code. The result stays on the outputs until the next accepted strobe. The comparator positions are fixed by convention:
- coarse line i sits on the boundary of cell 4(i+1);
- mid line k sits on the boundary of cell 4k+2;
- fine line k sits on the boundary of cell 4k+1;
- fine line 7+k sits on the boundary of cell 4k+3.

The eighth input of every multiplexer is tied low, so the top group of four cells has no mid or fine comparator.

Top module: `coarse_cell_coder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `valid_o` is 0 and `code_o` is 00000.
- R2: A strobe is accepted only when no conversion is in progress. The three comparator vectors are captured on the clock edge that accepts the strobe. Changes to them after that edge do not alter the result.
- R3: The upper field `code_o[4:2]` equals one plus the index of the highest asserted coarse line, or 0 when no coarse line is set. This also holds for non-monotonic vectors.
- R4: `code_o[1]` equals mid line number `code_o[4:2]`. It is 0 when `code_o[4:2]` is 7.
- R5: `code_o[0]` follows the fine bank chosen by `code_o[1]`. When `code_o[1]` is 0 it equals fine line `code_o[4:2]`. When `code_o[1]` is 1 it equals fine line 7+`code_o[4:2]`. It is 0 when `code_o[4:2]` is 7.
- R6: `valid_o` rises on the fourth clock edge after the edge that accepted the strobe, and stays 0 on the three edges in between.
- R7: While `valid_o` is 1, `code_o` holds still. The next accepted strobe clears `valid_o` on its own edge. `code_o` keeps the old value until the new result is loaded.
- R8: A strobe that arrives while a conversion is in progress is ignored. The running result and its timing stay unchanged.
- R9: A monotonic comparator pattern for a sample in cell L yields code L for L up to 27. It yields 11100 for any L from 28 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 1 | Strobe that starts a capture |
| coarse_i | input | 7 | Coarse thermometer, line i at cell boundary 4(i+1) |
| mid_i | input | 7 | Fourth-bit comparators, line k at cell boundary 4k+2 |
| fine_i | input | 14 | Fifth-bit comparators, lines 0..6 at 4k+1, lines 7..13 at 4k+3 |
| valid_o | output | 1 | Result valid |
| code_o | output | 5 | Cell code: [4:2] group, [1] fourth bit, [0] fifth bit |

## Verification
The assertions assume that `sample_i` is a clean, synchronous level that is 0 during reset, and that the comparator lines are free of X. They do not assume that the lines are monotonic, because the encoder must tolerate bubbles. The stimulus drives every input on the falling edge and holds the strobe for exactly one cycle. It sweeps all 32 cell levels with ideal thermometer patterns and then applies pseudo-random, bubbly vectors. It inverts the inputs straight after each capture to expose any late sampling.

// File: rtl/cellcode_pkg.sv
// Shared types for the coarse cell code generator.
package cellcode_pkg;
    // Conversion phase: idle/holding, then one phase per resolved field, then output load.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_MSB  = 3'd1,
        PH_B4   = 3'd2,
        PH_B5   = 3'd3,
        PH_OUT  = 3'd4
    } phase_t;
endpackage

// File: rtl/therm_prio_enc.sv
// Priority encoder for a (2**OUT_W - 1)-line thermometer vector.
// Output is one plus the index of the highest asserted line, 0 when none is set.
// Assumes nothing about monotonicity: bubbles below the top line are ignored.
module therm_prio_enc #(
    parameter int OUT_W = 3
) (
    input  logic [(2**OUT_W)-2:0] therm_i,
    output logic [OUT_W-1:0]      idx_o
);
    localparam int LINES = (2**OUT_W) - 1;

    // Scan upward so the highest set line wins.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (therm_i[i]) idx_o = OUT_W'(i + 1);
        end
    end
endmodule

// File: rtl/line_pick_mux.sv
// 8:1-style selector (2**SEL_W inputs) that routes one comparator line.
// The top input is tied to 0; a low enable forces the output to 0.
module line_pick_mux #(
    parameter int SEL_W = 3
) (
    input  logic [(2**SEL_W)-2:0] lines_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  en_i,
    output logic                  bit_o
);
    logic [(2**SEL_W)-1:0] ext;

    // Extend with the tied-low spare input, then pick and gate.
    always_comb begin
        ext   = {1'b0, lines_i};
        bit_o = en_i & ext[sel_i];
    end
endmodule

// File: rtl/coarse_cell_coder.sv
// Segmented coarse cell code generator.
// Captures 28 comparator decisions on an accepted strobe, then resolves the
// cell code in three clocked steps: group bits, fourth bit, fifth bit.
// valid_o rises one cycle after the last step and the code holds until the
// next accepted strobe. Assumes comparator lines are synchronous to clk.
module coarse_cell_coder #(
    parameter int MSB_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sample_i,
    input  logic [(2**MSB_W)-2:0]          coarse_i,
    input  logic [(2**MSB_W)-2:0]          mid_i,
    input  logic [2*((2**MSB_W)-1)-1:0]    fine_i,
    output logic                           valid_o,
    output logic [MSB_W+1:0]               code_o
);
    import cellcode_pkg::*;

    localparam int LINES  = (2**MSB_W) - 1;
    localparam int CODE_W = MSB_W + 2;
    localparam int BANKS  = 2;

    phase_t                   phase_q;
    logic [LINES-1:0]         coarse_q;
    logic [LINES-1:0]         mid_q;
    logic [BANKS*LINES-1:0]   fine_q;
    logic [MSB_W-1:0]         msb_q;
    logic [MSB_W-1:0]         msb_d;
    logic                     b4_q;
    logic                     b4_d;
    logic                     b5_q;
    logic [BANKS-1:0]         bank_bit;

    // Step 1 decoder: highest coarse line sets the group.
    therm_prio_enc #(.OUT_W(MSB_W)) u_enc (
        .therm_i (coarse_q),
        .idx_o   (msb_d)
    );

    // Step 2 selector: group picks one mid comparator.
    line_pick_mux #(.SEL_W(MSB_W)) u_mid_mux (
        .lines_i (mid_q),
        .sel_i   (msb_q),
        .en_i    (1'b1),
        .bit_o   (b4_d)
    );

    // Step 3 selectors: one bank per fourth-bit value, only the matching bank enabled.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        line_pick_mux #(.SEL_W(MSB_W)) u_fine_mux (
            .lines_i (fine_q[b*LINES +: LINES]),
            .sel_i   (msb_q),
            .en_i    (b4_q == 1'(b)),
            .bit_o   (bank_bit[b])
        );
    end

    // Phase sequencer with input capture and per-step result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            coarse_q <= '0;
            mid_q    <= '0;
            fine_q   <= '0;
            msb_q    <= '0;
            b4_q     <= 1'b0;
            b5_q     <= 1'b0;
            valid_o  <= 1'b0;
            code_o   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (sample_i) begin
                        coarse_q <= coarse_i;
                        mid_q    <= mid_i;
                        fine_q   <= fine_i;
                        valid_o  <= 1'b0;
                        phase_q  <= PH_MSB;
                    end
                end
                PH_MSB: begin
                    msb_q   <= msb_d;
                    phase_q <= PH_B4;
                end
                PH_B4: begin
                    b4_q    <= b4_d;
                    phase_q <= PH_B5;
                end
                PH_B5: begin
                    b5_q    <= |bank_bit;
                    phase_q <= PH_OUT;
                end
                PH_OUT: begin
                    code_o  <= CODE_W'({msb_q, b4_q, b5_q});
                    valid_o <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cellcode_chk.sv
// Property checker for coarse_cell_coder, attached by bind.
module cellcode_chk #(
    parameter int MSB_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_i,
    input logic             valid_o,
    input logic [MSB_W+1:0] code_o
);
    // R6
    valid_rise_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(sample_i, 5));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> $stable(code_o));

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(sample_i));

    // R5
    top_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (code_o[MSB_W+1:2] == '1)) |-> (code_o[1:0] == 2'b00));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && (code_o == '0)));
endmodule

bind coarse_cell_coder cellcode_chk #(.MSB_W(MSB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_i),
    .valid_o  (valid_o),
    .code_o   (code_o)
);

// File: tb/sim_coarse_cell_coder.sv
module sim_coarse_cell_coder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 1'b0;
    logic [6:0]  coarse_i = '0;
    logic [6:0]  mid_i = '0;
    logic [13:0] fine_i = '0;
    logic        valid_o;
    logic [4:0]  code_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    coarse_cell_coder #(.MSB_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .coarse_i(coarse_i), .mid_i(mid_i), .fine_i(fine_i),
        .valid_o(valid_o), .code_o(code_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model(input logic [6:0] c, input logic [6:0] m, input logic [13:0] f);
        logic [2:0] g;
        logic b4, b5;
        g = 3'd0;
        for (int i = 0; i < 7; i++) if (c[i]) g = 3'(i + 1);   // R3
        b4 = (g == 3'd7) ? 1'b0 : m[g];                        // R4
        if (g == 3'd7) b5 = 1'b0;                              // R5
        else b5 = b4 ? f[7 + int'(g)] : f[g];
        return {g, b4, b5};
    endfunction

    task automatic level_vecs(input int lv, output logic [6:0] c, output logic [6:0] m, output logic [13:0] f);
        for (int i = 0; i < 7; i++) begin
            c[i]     = (lv >= 4 * (i + 1));
            m[i]     = (lv >= 4 * i + 2);
            f[i]     = (lv >= 4 * i + 1);
            f[7 + i] = (lv >= 4 * i + 3);
        end
    endtask

    task automatic convert(input logic [6:0] c, input logic [6:0] m, input logic [13:0] f,
                           input logic [4:0] exp, input string req);
        @(negedge clk);
        coarse_i = c; mid_i = m; fine_i = f; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        coarse_i = ~c; mid_i = ~m; fine_i = ~f;   // R2: late changes must not matter
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R6 early", int'(valid_o), 0);
        @(negedge clk);
        check(valid_o == 1'b1, "R6 rise", int'(valid_o), 1);
        check(code_o == exp, req, int'(code_o), int'(exp));
    endtask

    initial begin
        logic [6:0]  c, m;
        logic [13:0] f;
        logic [4:0]  e;
        logic [4:0]  held;

        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
        check(code_o == 5'd0, "R1 code", int'(code_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(valid_o == 1'b0 && code_o == 5'd0, "R1 after release", int'(code_o), 0);

        // R9 sweep of all cell levels with ideal patterns
        for (int lv = 0; lv < 32; lv++) begin
            level_vecs(lv, c, m, f);
            e = (lv >= 28) ? 5'd28 : 5'(lv);
            convert(c, m, f, e, "R9 level");
        end

        // R3 R4 R5 with bubbly pseudo-random vectors
        for (int n = 0; n < 120; n++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            c = lfsr[6:0]; m = lfsr[13:7]; f = lfsr[27:14];
            if (n < 8) c = 7'(1 << n) | 7'(n);
            convert(c, m, f, model(c, m, f), "R3 R4 R5 random");
        end

        // R7 hold while idle with inputs moving
        level_vecs(13, c, m, f);
        convert(c, m, f, 5'd13, "R7 setup");
        held = code_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            coarse_i = 7'(k * 19); mid_i = 7'(k * 37); fine_i = 14'(k * 901);
        end
        check(valid_o == 1'b1, "R7 valid held", int'(valid_o), 1);
        check(code_o == held, "R7 code held", int'(code_o), int'(held));

        // R7 new strobe clears valid and keeps old code until reload
        level_vecs(22, c, m, f);
        @(negedge clk);
        coarse_i = c; mid_i = m; fine_i = f; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        check(valid_o == 1'b0, "R7 valid clear", int'(valid_o), 0);
        check(code_o == held, "R7 old code kept", int'(code_o), int'(held));
        repeat (3) @(negedge clk);
        check(code_o == held, "R7 code until reload", int'(code_o), int'(held));
        @(negedge clk);
        check(valid_o == 1'b1 && code_o == 5'd22, "R7 reload", int'(code_o), 22);

        // R8 strobe during conversion ignored, R2 capture at accepted edge
        level_vecs(6, c, m, f);
        @(negedge clk);
        coarse_i = c; mid_i = m; fine_i = f; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        @(negedge clk);
        level_vecs(30, c, m, f);
        coarse_i = c; mid_i = m; fine_i = f; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R8 timing kept", int'(valid_o), 0);
        @(negedge clk);
        check(valid_o == 1'b1, "R8 valid on time", int'(valid_o), 1);
        check(code_o == 5'd6, "R8 R2 first sample result", int'(code_o), 6);
        repeat (3) @(negedge clk);
        check(valid_o == 1'b1 && code_o == 5'd6, "R8 no second conversion", int'(code_o), 6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule